// File: doc/BRIEF.md
# ADC Channel Queue Sequencer

This block is the digital control side of a successive-approximation analog-to-digital converter. Software programs it through eight byte-wide registers; it chooses which analog input is sampled, starts the converter with a one-cycle strobe, and waits for the converter's done pulse. It then captures the result word into two read-only bytes and raises a conversion-complete flag.

Channels can be given one at a time or queued. In single-shot mode, a write to the channel register stops any conversion in flight and starts a new one on the written code. In queued mode, each channel write adds an entry to a small queue. Conversions do not begin until the queue holds a programmed number of entries. They then run back to back in the order the channels were written. The all-ones channel code is reserved as a stop command in both modes: it halts the converter and empties the queue.

Top module: `adcq_seq`

## Requirements
- R1: After reset, offset 0 reads 0x1F, offset 1 reads 0x08, offsets 2 to 7 read 0x00, conv_start is low and conv_chan is 0x1F.
- R2: Offsets 1, 2, 3, 6 and 7 read back the last byte written. Offset 0 reads back bits 6:0 as written, with the flag in bit 7. Writes to offsets 4 and 5 leave them unchanged.
- R3: In single-shot mode (offset 3 bit 3 = 0), writing channel code c (bits 4:0 of offset 0, c not 31) makes conv_start high for exactly one cycle, two cycles after the write edge, with conv_chan = c.
- R4: A single-shot write during a conversion aborts it. The cycle after the write edge is an idle gap in which conv_start is low and a done pulse is ignored. Only the new channel's result is captured.
- R5: Writing code 31 to offset 0 produces no start, halts any active conversion (its later done is ignored) and empties the queue.
- R6: A done pulse during a conversion loads the result word. Offset 5 returns bits 7:0 and offset 4 returns the bits above 7, zero-extended. Bit 7 of offset 0 (the complete flag) is set.
- R7: A read of offset 5 clears the complete flag.
- R8: In queued mode (offset 3 bit 3 = 1), channels are converted in the order they were written.
- R9: In queued mode, no conversion starts until the queue holds d+1 entries, where d is offset 3 bits 2:0. Once it is armed, the queue drains completely.
- R10: A queued write made while the queue holds its capacity (8 entries) is dropped.
- R11: The reserved codes 24 to 30 are accepted and start the converter on that code.
- R12: A done pulse while no conversion is active leaves the flag and the result unchanged.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_we | input | 1 | Register write strobe |
| bus_re | input | 1 | Register read strobe |
| bus_addr | input | 3 | Register offset |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data, registered one cycle after bus_re |
| conv_chan | output | 5 | Channel code presented to the converter |
| conv_start | output | 1 | One-cycle start strobe |
| conv_done | input | 1 | Converter completion pulse |
| conv_res | input | RES_W | Converter result word, valid with conv_done |

## Verification
The assertions assume that the converter raises conv_done for single cycles only and holds conv_res valid while it does. They also assume that a new start discards the converter's previous work. The bench converter model obeys both: it reloads a fixed-latency counter on every start and produces exactly one done per surviving start. Extra done pulses are injected only into the abort gap or while the block is idle, to exercise R4 and R12. The single-shot sweep covers every channel code. The queued sweep covers every depth setting.

// File: rtl/adcq_pkg.sv
package adcq_pkg;
  localparam int CHAN_W = 5;
  localparam logic [CHAN_W-1:0] CHAN_STOP = '1;

  typedef enum logic [2:0] {
    OFF_CHAN   = 3'd0,
    OFF_AUX1   = 3'd1,
    OFF_AUX2   = 3'd2,
    OFF_QCFG   = 3'd3,
    OFF_RES_HI = 3'd4,
    OFF_RES_LO = 3'd5,
    OFF_CMP_HI = 3'd6,
    OFF_CMP_LO = 3'd7
  } reg_off_e;

  typedef enum logic [1:0] {
    ST_IDLE   = 2'd0,
    ST_LAUNCH = 2'd1,
    ST_BUSY   = 2'd2
  } ctl_state_e;
endpackage

// File: rtl/adcq_chan_queue.sv
module adcq_chan_queue #(
  parameter int ENTRIES = 8,
  parameter int DATA_W  = 5,
  localparam int PTR_W  = $clog2(ENTRIES),
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              push,
  input  logic              pop,
  input  logic              flush,
  input  logic [DATA_W-1:0] wr_data,
  output logic [DATA_W-1:0] head,
  output logic [CNT_W-1:0]  count,
  output logic              empty
);
  logic [DATA_W-1:0] mem [ENTRIES];
  logic [PTR_W-1:0]  wr_ptr, rd_ptr;
  logic              full, push_ok, pop_ok;

  assign full    = (count == CNT_W'(ENTRIES));
  assign empty   = (count == '0);
  assign push_ok = push && !full;
  assign pop_ok  = pop && !empty;
  assign head    = mem[rd_ptr];

  always_ff @(posedge clk) begin
    if (push_ok) mem[wr_ptr] <= wr_data;
  end

  always_ff @(posedge clk) begin
    if (rst || flush) begin
      wr_ptr <= '0;
      rd_ptr <= '0;
      count  <= '0;
    end else begin
      if (push_ok) wr_ptr <= wr_ptr + 1'b1;
      if (pop_ok)  rd_ptr <= rd_ptr + 1'b1;
      case ({push_ok, pop_ok})
        2'b10:   count <= count + 1'b1;
        2'b01:   count <= count - 1'b1;
        default: count <= count;
      endcase
    end
  end

  assert_no_overflow_R10: assert property (@(posedge clk) disable iff (rst)
    count <= CNT_W'(ENTRIES));
  assert_pop_nonempty_R8: assert property (@(posedge clk) disable iff (rst)
    pop |-> !empty);
endmodule

// File: rtl/adcq_conv_ctrl.sv
module adcq_conv_ctrl
  import adcq_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int ENTRIES = 8,
  localparam int CNT_W  = $clog2(ENTRIES + 1)
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              chan_wr,
  input  logic [CHAN_W-1:0] chan_code,
  input  logic              fifo_en,
  input  logic [2:0]        depth_code,
  input  logic [CHAN_W-1:0] q_head,
  input  logic [CNT_W-1:0]  q_count,
  input  logic              q_empty,
  output logic              q_push,
  output logic              q_pop,
  output logic              q_flush,
  input  logic              conv_done,
  input  logic [RES_W-1:0]  conv_res,
  output logic              conv_start,
  output logic [CHAN_W-1:0] conv_chan,
  output logic              res_load,
  output logic [RES_W-1:0]  res_word
);
  ctl_state_e state;
  logic       armed, is_stop, direct, reached;

  assign is_stop = chan_wr && (chan_code == CHAN_STOP);
  assign direct  = chan_wr && !fifo_en && !is_stop;
  assign q_flush = is_stop;
  assign q_push  = chan_wr && fifo_en && !is_stop;
  assign reached = int'(q_count) >= int'(depth_code) + 1;
  assign q_pop   = (state == ST_IDLE) && fifo_en && !q_empty && !is_stop && (armed || reached);

  always_ff @(posedge clk) begin
    if (rst) begin
      state      <= ST_IDLE;
      armed      <= 1'b0;
      conv_start <= 1'b0;
      conv_chan  <= CHAN_STOP;
      res_load   <= 1'b0;
      res_word   <= '0;
    end else begin
      conv_start <= 1'b0;
      res_load   <= 1'b0;
      if (is_stop) begin
        state <= ST_IDLE;
        armed <= 1'b0;
      end else if (direct) begin
        state     <= ST_LAUNCH;
        conv_chan <= chan_code;
      end else if (q_pop) begin
        state     <= ST_LAUNCH;
        conv_chan <= q_head;
        armed     <= 1'b1;
      end else if (state == ST_LAUNCH) begin
        conv_start <= 1'b1;
        state      <= ST_BUSY;
      end else if (state == ST_BUSY) begin
        if (conv_done) begin
          res_word <= conv_res;
          res_load <= 1'b1;
          state    <= ST_IDLE;
        end
      end else if (q_empty && !q_push) begin
        armed <= 1'b0;
      end
    end
  end

  assert_start_single_R3: assert property (@(posedge clk) disable iff (rst)
    conv_start |=> !conv_start);
  assert_abort_gap_R4: assert property (@(posedge clk) disable iff (rst)
    (chan_wr && !fifo_en) |=> !conv_start);
  assert_stop_no_start_R5: assert property (@(posedge clk) disable iff (rst)
    is_stop |=> !conv_start);
  assert_result_only_on_load_R6: assert property (@(posedge clk) disable iff (rst)
    !$stable(res_word) |-> res_load);
endmodule

// File: rtl/adcq_seq.sv
module adcq_seq
  import adcq_pkg::*;
#(
  parameter int RES_W   = 12,
  parameter int ENTRIES = 8
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             bus_we,
  input  logic             bus_re,
  input  logic [2:0]       bus_addr,
  input  logic [7:0]       bus_wdata,
  output logic [7:0]       bus_rdata,
  output logic [4:0]       conv_chan,
  output logic             conv_start,
  input  logic             conv_done,
  input  logic [RES_W-1:0] conv_res
);
  localparam int CNT_W = $clog2(ENTRIES + 1);

  reg_off_e          off;
  logic [CHAN_W-1:0] chan_field;
  logic [1:0]        chan_misc;
  logic              done_flag;
  logic [7:0]        aux1_q, aux2_q, qcfg_q, cmph_q, cmpl_q;
  logic              chan_wr, rd_lo;
  logic              q_push, q_pop, q_flush, q_empty, res_load;
  logic [CHAN_W-1:0] q_head;
  logic [CNT_W-1:0]  q_count;
  logic [RES_W-1:0]  res_word;
  logic [7:0]        res_hi, res_lo;

  assign off     = reg_off_e'(bus_addr);
  assign chan_wr = bus_we && (off == OFF_CHAN);
  assign rd_lo   = bus_re && (off == OFF_RES_LO);
  assign res_hi  = 8'(res_word >> 8);
  assign res_lo  = res_word[7:0];

  always_ff @(posedge clk) begin
    if (rst) begin
      chan_field <= CHAN_STOP;
      chan_misc  <= '0;
      aux1_q     <= 8'h08;
      aux2_q     <= '0;
      qcfg_q     <= '0;
      cmph_q     <= '0;
      cmpl_q     <= '0;
    end else if (bus_we) begin
      case (off)
        OFF_CHAN: begin
          chan_field <= bus_wdata[4:0];
          chan_misc  <= bus_wdata[6:5];
        end
        OFF_AUX1:   aux1_q <= bus_wdata;
        OFF_AUX2:   aux2_q <= bus_wdata;
        OFF_QCFG:   qcfg_q <= bus_wdata;
        OFF_CMP_HI: cmph_q <= bus_wdata;
        OFF_CMP_LO: cmpl_q <= bus_wdata;
        default: ;
      endcase
    end
  end

  always_ff @(posedge clk) begin
    if (rst)           done_flag <= 1'b0;
    else if (res_load) done_flag <= 1'b1;
    else if (rd_lo)    done_flag <= 1'b0;
  end

  always_ff @(posedge clk) begin
    if (rst) begin
      bus_rdata <= '0;
    end else if (bus_re) begin
      case (off)
        OFF_CHAN:   bus_rdata <= {done_flag, chan_misc, chan_field};
        OFF_AUX1:   bus_rdata <= aux1_q;
        OFF_AUX2:   bus_rdata <= aux2_q;
        OFF_QCFG:   bus_rdata <= qcfg_q;
        OFF_RES_HI: bus_rdata <= res_hi;
        OFF_RES_LO: bus_rdata <= res_lo;
        OFF_CMP_HI: bus_rdata <= cmph_q;
        default:    bus_rdata <= cmpl_q;
      endcase
    end
  end

  adcq_chan_queue #(.ENTRIES(ENTRIES), .DATA_W(CHAN_W)) u_queue (
    .clk     (clk),
    .rst     (rst),
    .push    (q_push),
    .pop     (q_pop),
    .flush   (q_flush),
    .wr_data (bus_wdata[4:0]),
    .head    (q_head),
    .count   (q_count),
    .empty   (q_empty)
  );

  adcq_conv_ctrl #(.RES_W(RES_W), .ENTRIES(ENTRIES)) u_ctrl (
    .clk        (clk),
    .rst        (rst),
    .chan_wr    (chan_wr),
    .chan_code  (bus_wdata[4:0]),
    .fifo_en    (qcfg_q[3]),
    .depth_code (qcfg_q[2:0]),
    .q_head     (q_head),
    .q_count    (q_count),
    .q_empty    (q_empty),
    .q_push     (q_push),
    .q_pop      (q_pop),
    .q_flush    (q_flush),
    .conv_done  (conv_done),
    .conv_res   (conv_res),
    .conv_start (conv_start),
    .conv_chan  (conv_chan),
    .res_load   (res_load),
    .res_word   (res_word)
  );

  assert_flag_from_load_R6: assert property (@(posedge clk) disable iff (rst)
    $rose(done_flag) |-> $past(res_load));
  assert_flag_clear_R7: assert property (@(posedge clk) disable iff (rst)
    (rd_lo && !res_load) |=> !done_flag);
endmodule

// File: tb/adcq_seq_bench.sv
module adcq_seq_bench;
  localparam int RES_W = 12;
  localparam int LAT   = 10;

  logic             clk = 1'b0;
  logic             rst = 1'b1;
  logic             bus_we = 1'b0, bus_re = 1'b0;
  logic [2:0]       bus_addr = '0;
  logic [7:0]       bus_wdata = '0;
  logic [7:0]       bus_rdata;
  logic [4:0]       conv_chan;
  logic             conv_start;
  logic             conv_done;
  logic [RES_W-1:0] conv_res;

  int nchecks = 0, nerr = 0, nstart = 0;
  bit finished = 0;
  logic [4:0] log_q [256];
  logic [4:0] exp_q [16];

  int               cnt = 0;
  logic             mdone = 1'b0, inj_done = 1'b0;
  logic [4:0]       mchan = '0;
  logic [RES_W-1:0] mres = '0;

  always #2 clk = ~clk;

  adcq_seq u_adcq_seq (
    .clk(clk), .rst(rst), .bus_we(bus_we), .bus_re(bus_re), .bus_addr(bus_addr),
    .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .conv_chan(conv_chan),
    .conv_start(conv_start), .conv_done(conv_done), .conv_res(conv_res)
  );

  function automatic logic [RES_W-1:0] fres(input logic [4:0] c);
    return RES_W'((int'(c) * 149 + 37) % 4096);
  endfunction

  assign conv_done = mdone | inj_done;
  assign conv_res  = mres;

  always @(posedge clk) begin
    if (rst) begin
      cnt <= 0; mdone <= 1'b0;
    end else begin
      mdone <= 1'b0;
      if (conv_start) begin
        cnt <= LAT; mchan <= conv_chan;
        log_q[nstart % 256] <= conv_chan;
        nstart <= nstart + 1;
      end else if (cnt != 0) begin
        cnt <= cnt - 1;
        if (cnt == 1) begin mdone <= 1'b1; mres <= fres(mchan); end
      end
    end
  end

  task automatic tick(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic chk(input string tag, input int act, input int exp);
    nchecks++;
    if (act !== exp) begin
      nerr++;
      $display("FAIL %s: actual %0d expected %0d", tag, act, exp);
    end
  endtask

  task automatic wr(input logic [2:0] a, input logic [7:0] d);
    bus_we = 1'b1; bus_addr = a; bus_wdata = d;
    @(negedge clk);
    bus_we = 1'b0;
  endtask

  task automatic rd(input logic [2:0] a, output logic [7:0] d);
    bus_re = 1'b1; bus_addr = a;
    @(negedge clk);
    bus_re = 1'b0;
    d = bus_rdata;
  endtask

  task automatic finish_run();
    if (!finished) begin
      finished = 1;
      $display("Simulation finished: %0d checks, %0d errors", nchecks, nerr);
      $finish;
    end
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    nchecks++; nerr++;
    $display("FAIL watchdog: actual hung expected completion");
    finish_run();
  end

  initial begin
    logic [7:0] d;
    logic [RES_W-1:0] r;
    int base;
    tick(3);
    rst = 1'b0;
    tick(1);
    // R1 reset values
    chk("R1 conv_start", int'(conv_start), 0);
    chk("R1 conv_chan", int'(conv_chan), 31);
    for (int a = 0; a < 8; a++) begin
      rd(3'(a), d);
      chk($sformatf("R1 offset %0d", a), int'(d), a == 0 ? 31 : (a == 1 ? 8 : 0));
    end

    // R3 R6 R7 R11 sweep over every single-shot code
    for (int c = 0; c < 31; c++) begin
      base = nstart;
      wr(3'd0, 8'(c));
      chk("R3 gap cycle", int'(conv_start), 0);
      tick(1);
      chk("R3 start pulse", int'(conv_start), 1);
      chk(c >= 24 ? "R11 reserved code chan" : "R3 chan", int'(conv_chan), c);
      tick(1);
      chk("R3 start ends", int'(conv_start), 0);
      tick(20);
      r = fres(5'(c));
      rd(3'd0, d);
      chk("R6 flag set", int'(d), 128 + c);
      rd(3'd5, d);
      chk("R6 result low", int'(d), int'(r[7:0]));
      rd(3'd4, d);
      chk("R6 result high", int'(d), int'(r) / 256);
      rd(3'd0, d);
      chk("R7 flag cleared", int'(d), c);
      chk("R3 start count", nstart - base, 1);
    end

    // R5 stop code in single-shot mode
    base = nstart;
    wr(3'd0, 8'h1F);
    tick(4);
    chk("R5 stop no start", nstart - base, 0);

    // R4 abort with a stray done in the gap
    base = nstart;
    wr(3'd0, 8'd3);
    tick(4);
    wr(3'd0, 8'd9);
    inj_done = 1'b1;
    @(negedge clk);
    inj_done = 1'b0;
    rd(3'd0, d);
    chk("R4 gap done ignored", int'(d), 9);
    tick(20);
    r = fres(5'd9);
    rd(3'd5, d);
    chk("R4 new result low", int'(d), int'(r[7:0]));
    chk("R4 two starts", nstart - base, 2);
    chk("R4 last chan", int'(log_q[(nstart - 1) % 256]), 9);

    // R12 done while idle
    inj_done = 1'b1;
    @(negedge clk);
    inj_done = 1'b0;
    tick(2);
    rd(3'd0, d);
    chk("R12 idle done flag", int'(d), 9);
    rd(3'd5, d);
    chk("R12 idle done result", int'(d), int'(r[7:0]));

    // R2 register storage and read-only results
    wr(3'd1, 8'hA5); rd(3'd1, d); chk("R2 offset1", int'(d), 165);
    wr(3'd2, 8'h5A); rd(3'd2, d); chk("R2 offset2", int'(d), 90);
    wr(3'd6, 8'h3C); rd(3'd6, d); chk("R2 offset6", int'(d), 60);
    wr(3'd7, 8'hC3); rd(3'd7, d); chk("R2 offset7", int'(d), 195);
    wr(3'd3, 8'h75); rd(3'd3, d); chk("R2 offset3", int'(d), 117);
    wr(3'd3, 8'h00);
    wr(3'd4, 8'hFF); rd(3'd4, d); chk("R2 offset4 read-only", int'(r) / 256, int'(d));
    wr(3'd5, 8'hEE); rd(3'd5, d); chk("R2 offset5 read-only", int'(d), int'(r[7:0]));
    wr(3'd0, 8'h7F); rd(3'd0, d); chk("R2 offset0 misc bits", int'(d), 127);

    // R8 R9 queued mode over every depth
    for (int dp = 1; dp <= 8; dp++) begin
      wr(3'd3, 8'(8 + dp - 1));
      base = nstart;
      for (int k = 0; k < dp; k++) begin
        exp_q[k] = 5'((k * 5 + dp) % 24);
        wr(3'd0, {3'b000, exp_q[k]});
        if (k < dp - 1) begin
          tick(3);
          chk("R9 held below depth", nstart - base, 0);
        end
      end
      tick(16 * dp + 10);
      chk("R9 all converted", nstart - base, dp);
      for (int k = 0; k < dp; k++)
        chk("R8 order", int'(log_q[(base + k) % 256]), int'(exp_q[k]));
      r = fres(exp_q[dp - 1]);
      rd(3'd5, d);
      chk("R8 last result", int'(d), int'(r[7:0]));
    end

    // R5 flush before arming
    wr(3'd3, 8'h0B);
    base = nstart;
    wr(3'd0, 8'd1); wr(3'd0, 8'd2);
    wr(3'd0, 8'h1F);
    wr(3'd0, 8'd4); wr(3'd0, 8'd5);
    tick(6);
    chk("R5 flushed entries gone", nstart - base, 0);
    wr(3'd0, 8'd6); wr(3'd0, 8'd7);
    tick(80);
    chk("R5 refill count", nstart - base, 4);
    for (int k = 0; k < 4; k++)
      chk("R5 refill order", int'(log_q[(base + k) % 256]), 4 + k);

    // R5 flush mid-conversion
    rd(3'd5, d);
    wr(3'd3, 8'h09);
    base = nstart;
    wr(3'd0, 8'd4); wr(3'd0, 8'd5);
    tick(4);
    wr(3'd0, 8'h1F);
    tick(40);
    chk("R5 halted count", nstart - base, 1);
    rd(3'd0, d);
    chk("R5 halted no flag", int'(d), 31);

    // R10 overflow drop
    wr(3'd3, 8'h0F);
    base = nstart;
    for (int k = 0; k < 8; k++) wr(3'd0, 8'(10 + k));
    tick(3);
    chk("R10 first started", nstart - base, 1);
    for (int k = 0; k < 3; k++) wr(3'd0, 8'(18 + k));
    tick(9 * 16 + 10);
    chk("R10 drop count", nstart - base, 9);
    for (int k = 0; k < 9; k++)
      chk("R10 kept order", int'(log_q[(base + k) % 256]), 10 + k);

    wr(3'd3, 8'h00);
    tick(2);
    finish_run();
  end
endmodule